// File: doc/BRIEF.md
# Control Packet Replay Buffer

This block sits on the transmit path of a serial link, in front of the link arbiter, and handles only the control traffic class. A control packet is written into it one 16-bit word at a time. The block then asks the arbiter for the link and streams the packet out. It keeps the copy until the far end returns a positive acknowledgement. Bulk data packets do not pass through this block and are never replayed. Framing and CRC generation happen elsewhere.

Only one packet is outstanding at a time. The receiver reports the far end's verdict as single-cycle acknowledge or reject pulses. A reject, which the far end sends after a CRC failure, replays the stored packet from its first word. A silence longer than a programmable number of cycles is treated in the same way. A programmable retry budget bounds the number of replays. When the budget is used up, the block raises a fatal link flag and stops transmitting until reset.

Top module: `ctl_replay_buf`

## Requirements
- R1: After reset, wr_ready is 1, tx_req is 0 and link_fatal is 0.
- R2: While wr_ready is 1, each cycle with wr_valid high stores wr_data as the next word, starting from index 0. A word with wr_last high, or the DEPTH-th word, closes the packet. In the cycle after the close, wr_ready is 0 and tx_req is 1.
- R3: While tx_req is 1, tx_data shows the stored words in write order from index 0, and tx_last is 1 on the final word. Each cycle with tx_grant high moves to the next word. While tx_grant is low, tx_data and tx_last hold. The cycle after the final word is granted, tx_req is 0 and the block waits for a response.
- R4: A reject pulse (nack_in) while waiting starts a replay from word 0, with tx_req high in the next cycle.
- R5: An acknowledge pulse (ack_in) while waiting releases the stored copy, and wr_ready is 1 in the next cycle. When both pulses arrive in the same cycle, the acknowledge wins.
- R6: If no response arrives while waiting, tx_req rises again after exactly cfg_timeout cycles with tx_req low (cfg_timeout of 1 or more), and the replay starts from word 0.
- R7: At most cfg_max_retry replays are made for one packet. A further reject or timeout sets link_fatal. From then until reset, link_fatal stays 1 and tx_req and wr_ready stay 0, whatever ack_in and nack_in do.
- R8: ack_in and nack_in have no effect while a packet is being transmitted.
- R9: wr_valid has no effect while wr_ready is 0. The stored packet is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_timeout | input | TMO_W | Response timeout in cycles |
| cfg_max_retry | input | RTY_W | Replay budget per packet |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Block can accept a packet word |
| wr_data | input | WORD_W | Packet word |
| wr_last | input | 1 | Final word of the packet |
| ack_in | input | 1 | Far-end acknowledge pulse |
| nack_in | input | 1 | Far-end reject pulse |
| tx_req | output | 1 | Request to the link arbiter |
| tx_grant | input | 1 | Arbiter takes the current word |
| tx_data | output | WORD_W | Word offered to the link |
| tx_last | output | 1 | Offered word is the final one |
| link_fatal | output | 1 | Retry budget exhausted |

## Verification
Every packet length from 1 to DEPTH is sent and acknowledged. The words are derived arithmetically from the length, so a wrong order, a skipped word or a stale word shows up in the data. A packet closed only by the depth limit shows whether the forced close works. The timeout is swept over several values, and the measured gap tells an off-by-one in the timer from a correct count. The retry budget is swept from zero upward, which shows whether the fatal flag comes after exactly the allowed number of replays. Further tests cover responses that arrive mid-transmission, writes while busy, a stalled grant and simultaneous acknowledge and reject. Each of these shows either a correct replay of the untouched copy or a corrupted or premature one.

// File: rtl/crb_pkg.sv
`timescale 1ns/1ps
package crb_pkg;
   typedef enum logic [1:0] {
      ST_LOAD = 2'd0,
      ST_SEND = 2'd1,
      ST_WAIT = 2'd2,
      ST_DEAD = 2'd3
   } crb_state_e;
endpackage

// File: rtl/crb_store.sv
`timescale 1ns/1ps
module crb_store #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 32,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PTR_W-1:0]  widx,
   input  logic [WORD_W-1:0] wdata,
   input  logic [PTR_W-1:0]  ridx,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] view [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (we && (widx == PTR_W'(i))) word_q <= wdata;
      end
      assign view[i] = word_q;
   end

   assign rdata = view[ridx];
endmodule

// File: rtl/crb_timer.sv
`timescale 1ns/1ps
module crb_timer #(
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   logic [TMO_W-1:0] cnt_q;
   logic [TMO_W:0]   nxt;

   assign nxt     = {1'b0, cnt_q} + 1'b1;
   assign expired = run && (nxt >= {1'b0, limit});

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt_q <= '0;
      else if (!expired)  cnt_q <= nxt[TMO_W-1:0];
   end
endmodule

// File: rtl/crb_ctrl.sv
`timescale 1ns/1ps
module crb_ctrl
   import crb_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int RTY_W = 3,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RTY_W-1:0] max_retry,
   input  logic             wr_valid,
   input  logic             wr_last,
   input  logic             tx_grant,
   input  logic             ack,
   input  logic             nack,
   input  logic             tmo_hit,
   output logic             wr_ready,
   output logic             store_we,
   output logic [PTR_W-1:0] store_widx,
   output logic [PTR_W-1:0] rd_idx,
   output logic             tx_req,
   output logic             tx_last,
   output logic             waiting,
   output logic             fatal
);
   crb_state_e       state_q;
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q, last_q;
   logic [RTY_W-1:0] tries_q;
   logic             close, replay;

   assign wr_ready   = (state_q == ST_LOAD);
   assign tx_req     = (state_q == ST_SEND);
   assign waiting    = (state_q == ST_WAIT);
   assign fatal      = (state_q == ST_DEAD);
   assign store_we   = wr_ready && wr_valid;
   assign store_widx = wr_ptr_q;
   assign rd_idx     = rd_ptr_q;
   assign tx_last    = tx_req && (rd_ptr_q == last_q);
   assign close      = store_we && (wr_last || wr_ptr_q == PTR_W'(DEPTH - 1));
   assign replay     = waiting && !ack && (nack || tmo_hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_LOAD;
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         last_q   <= '0;
         tries_q  <= '0;
      end else begin
         unique case (state_q)
            ST_LOAD: if (store_we) begin
               if (close) begin
                  last_q   <= wr_ptr_q;
                  wr_ptr_q <= '0;
                  rd_ptr_q <= '0;
                  tries_q  <= '0;
                  state_q  <= ST_SEND;
               end else begin
                  wr_ptr_q <= wr_ptr_q + 1'b1;
               end
            end
            ST_SEND: if (tx_grant) begin
               if (rd_ptr_q == last_q) state_q  <= ST_WAIT;
               else                    rd_ptr_q <= rd_ptr_q + 1'b1;
            end
            ST_WAIT: begin
               if (ack) begin
                  state_q <= ST_LOAD;
               end else if (replay) begin
                  if (tries_q == max_retry) begin
                     state_q <= ST_DEAD;
                  end else begin
                     tries_q  <= tries_q + 1'b1;
                     rd_ptr_q <= '0;
                     state_q  <= ST_SEND;
                  end
               end
            end
            default: state_q <= ST_DEAD;
         endcase
      end
   end
endmodule

// File: rtl/ctl_replay_buf.sv
`timescale 1ns/1ps
module ctl_replay_buf #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 32,
   parameter int TMO_W  = 8,
   parameter int RTY_W  = 3,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TMO_W-1:0]  cfg_timeout,
   input  logic [RTY_W-1:0]  cfg_max_retry,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              wr_last,
   input  logic              ack_in,
   input  logic              nack_in,
   output logic              tx_req,
   input  logic              tx_grant,
   output logic [WORD_W-1:0] tx_data,
   output logic              tx_last,
   output logic              link_fatal
);
   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 2");
   end
   if (WORD_W < 1 || TMO_W < 1 || RTY_W < 1) begin : g_bad_width
      $error("WORD_W, TMO_W and RTY_W must be positive");
   end

   logic             we, waiting, tmo_hit;
   logic [PTR_W-1:0] widx, ridx;

   crb_ctrl #(.DEPTH(DEPTH), .RTY_W(RTY_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .max_retry  (cfg_max_retry),
      .wr_valid   (wr_valid),
      .wr_last    (wr_last),
      .tx_grant   (tx_grant),
      .ack        (ack_in),
      .nack       (nack_in),
      .tmo_hit    (tmo_hit),
      .wr_ready   (wr_ready),
      .store_we   (we),
      .store_widx (widx),
      .rd_idx     (ridx),
      .tx_req     (tx_req),
      .tx_last    (tx_last),
      .waiting    (waiting),
      .fatal      (link_fatal)
   );

   crb_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .we    (we),
      .widx  (widx),
      .wdata (wr_data),
      .ridx  (ridx),
      .rdata (tx_data)
   );

   crb_timer #(.TMO_W(TMO_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (waiting),
      .limit   (cfg_timeout),
      .expired (tmo_hit)
   );
endmodule

// File: rtl/crb_chk.sv
`timescale 1ns/1ps
module crb_chk #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic              wr_last,
   input logic              ack_in,
   input logic              nack_in,
   input logic              tx_req,
   input logic              tx_grant,
   input logic [WORD_W-1:0] tx_data,
   input logic              tx_last,
   input logic              link_fatal
);
   logic idle_wait;
   assign idle_wait = !tx_req && !wr_ready && !link_fatal;

   assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_req && wr_ready));

   assert_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && wr_last) |=> (tx_req && !wr_ready));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !tx_grant) |=> (tx_req && $stable(tx_data) && $stable(tx_last)));

   assert_replay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_wait && nack_in && !ack_in) |=> (tx_req || link_fatal));

   assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_wait && ack_in) |=> wr_ready);

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      link_fatal |=> (link_fatal && !tx_req && !wr_ready));

   assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !tx_last && (ack_in || nack_in)) |=> tx_req);
endmodule

bind ctl_replay_buf crb_chk #(.WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_valid   (wr_valid),
   .wr_ready   (wr_ready),
   .wr_last    (wr_last),
   .ack_in     (ack_in),
   .nack_in    (nack_in),
   .tx_req     (tx_req),
   .tx_grant   (tx_grant),
   .tx_data    (tx_data),
   .tx_last    (tx_last),
   .link_fatal (link_fatal)
);

// File: tb/ctl_replay_buf_bench.sv
`timescale 1ns/1ps
module ctl_replay_buf_bench;
   localparam int WORD_W = 16;
   localparam int DEPTH  = 32;
   localparam int TMO_W  = 8;
   localparam int RTY_W  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [TMO_W-1:0]  cfg_timeout = 8'd200;
   logic [RTY_W-1:0]  cfg_max_retry = 3'd7;
   logic              wr_valid = 1'b0, wr_last = 1'b0;
   logic [WORD_W-1:0] wr_data = '0;
   logic              ack_in = 1'b0, nack_in = 1'b0, tx_grant = 1'b1;
   logic              wr_ready, tx_req, tx_last, link_fatal;
   logic [WORD_W-1:0] tx_data;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ctl_replay_buf #(.WORD_W(WORD_W), .DEPTH(DEPTH), .TMO_W(TMO_W), .RTY_W(RTY_W))
   u_ctl_replay_buf (
      .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout), .cfg_max_retry(cfg_max_retry),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
      .ack_in(ack_in), .nack_in(nack_in), .tx_req(tx_req), .tx_grant(tx_grant),
      .tx_data(tx_data), .tx_last(tx_last), .link_fatal(link_fatal)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [WORD_W-1:0] word_of(input int base, input int i);
      return WORD_W'(base * 16'h0101 + i * 3);
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic write_pkt(input int len, input int base, input bit use_last);
      for (int i = 0; i < len; i++) begin
         wr_valid = 1'b1;
         wr_data  = word_of(base, i);
         wr_last  = use_last && (i == len - 1);
         chk(wr_ready == 1'b1, "R2 ready while loading", int'(wr_ready), 1);
         @(negedge clk);
      end
      wr_valid = 1'b0;
      wr_last  = 1'b0;
   endtask

   task automatic expect_stream(input int len, input int base, input string req);
      for (int i = 0; i < len; i++) begin
         chk(tx_req == 1'b1, req, int'(tx_req), 1);
         chk(tx_data == word_of(base, i), req, int'(tx_data), int'(word_of(base, i)));
         chk(tx_last == (i == len - 1), req, int'(tx_last), int'(i == len - 1));
         @(negedge clk);
      end
   endtask

   task automatic pulse(input bit a, input bit n);
      ack_in = a; nack_in = n;
      @(negedge clk);
      ack_in = 1'b0; nack_in = 1'b0;
   endtask

   task automatic measure_gap(output int gap);
      gap = 0;
      while (!tx_req && !link_fatal && gap < 1000) begin
         gap++;
         @(negedge clk);
      end
   endtask

   initial begin
      int gap;
      do_reset();
      // R1 reset state
      chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
      chk(tx_req == 1'b0, "R1 tx_req", int'(tx_req), 0);
      chk(link_fatal == 1'b0, "R1 link_fatal", int'(link_fatal), 0);

      // R2 R3 R5: every length, acknowledged
      for (int len = 1; len <= DEPTH; len++) begin
         write_pkt(len, len, 1'b1);
         expect_stream(len, len, "R3 stream");
         chk(tx_req == 1'b0 && wr_ready == 1'b0, "R3 waiting", int'(tx_req), 0);
         pulse(1'b1, 1'b0);
         chk(wr_ready == 1'b1, "R5 release", int'(wr_ready), 1);
      end

      // R2 forced close at DEPTH words without last
      write_pkt(DEPTH, 77, 1'b0);
      expect_stream(DEPTH, 77, "R2 forced close");
      pulse(1'b1, 1'b0);

      // R4 reject replay
      write_pkt(6, 5, 1'b1);
      expect_stream(6, 5, "R3 first send");
      pulse(1'b0, 1'b1);
      expect_stream(6, 5, "R4 replay");
      // R9 writes while busy ignored
      for (int k = 0; k < 3; k++) begin
         wr_valid = 1'b1; wr_last = 1'b1; wr_data = 16'hBEEF;
         chk(wr_ready == 1'b0, "R9 busy", int'(wr_ready), 0);
         @(negedge clk);
      end
      wr_valid = 1'b0; wr_last = 1'b0;
      pulse(1'b0, 1'b1);
      expect_stream(6, 5, "R9 copy intact");
      // R5 ack wins over nack
      pulse(1'b1, 1'b1);
      chk(wr_ready == 1'b1 && tx_req == 1'b0, "R5 ack wins", int'(wr_ready), 1);

      // R8 responses during transmission ignored
      write_pkt(8, 9, 1'b1);
      for (int i = 0; i < 8; i++) begin
         ack_in = (i == 3); nack_in = (i == 3) || (i == 5);
         chk(tx_req == 1'b1 && tx_data == word_of(9, i), "R8 stream", int'(tx_data), int'(word_of(9, i)));
         @(negedge clk);
      end
      ack_in = 1'b0; nack_in = 1'b0;
      chk(wr_ready == 1'b0 && tx_req == 1'b0, "R8 still waiting", int'(wr_ready), 0);
      pulse(1'b0, 1'b1);
      expect_stream(8, 9, "R8 replay intact");
      pulse(1'b1, 1'b0);

      // R3 grant stall
      write_pkt(5, 3, 1'b1);
      tx_grant = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk(tx_req == 1'b1 && tx_data == word_of(3, 0), "R3 stall hold", int'(tx_data), int'(word_of(3, 0)));
         @(negedge clk);
      end
      tx_grant = 1'b1;
      expect_stream(5, 3, "R3 after stall");
      pulse(1'b1, 1'b0);

      // R6 timeout sweep
      for (int t = 1; t <= 6; t++) begin
         cfg_timeout = TMO_W'(t);
         write_pkt(4, 20 + t, 1'b1);
         expect_stream(4, 20 + t, "R6 first send");
         measure_gap(gap);
         chk(gap == t, "R6 timeout gap", gap, t);
         expect_stream(4, 20 + t, "R6 timeout replay");
         pulse(1'b1, 1'b0);
      end

      // R7 retry budget sweep
      for (int m = 0; m <= 3; m++) begin
         do_reset();
         cfg_timeout = 8'd3;
         cfg_max_retry = RTY_W'(m);
         write_pkt(4, 40 + m, 1'b1);
         expect_stream(4, 40 + m, "R7 first send");
         for (int r = 0; r < m; r++) begin
            measure_gap(gap);
            chk(gap == 3 && link_fatal == 1'b0, "R7 replay allowed", gap, 3);
            expect_stream(4, 40 + m, "R7 replay");
         end
         repeat (3) @(negedge clk);
         chk(link_fatal == 1'b1, "R7 fatal", int'(link_fatal), 1);
         chk(tx_req == 1'b0 && wr_ready == 1'b0, "R7 quiet", int'(tx_req), 0);
         pulse(1'b1, 1'b0);
         pulse(1'b0, 1'b1);
         repeat (5) @(negedge clk);
         chk(link_fatal == 1'b1 && tx_req == 1'b0 && wr_ready == 1'b0, "R7 sticky", int'(link_fatal), 1);
      end

      do_reset();
      chk(link_fatal == 1'b0 && wr_ready == 1'b1, "R1 reset clears fatal", int'(link_fatal), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule